// File: doc/BRIEF.md
# Page LZ Compressor with Small Window

This block is a streaming string-match compressor for memory pages. Bytes of one page enter on a valid/ready input. The block keeps the most recent 1024 bytes of that page in a history that it searches associatively: every history position is compared with the incoming byte in the same cycle. It writes a stream of 8-bit words. Each word is either a literal or part of a three-word back-reference token. All of its state is cleared when a page ends, so every page is compressed on its own and a new page starts with no setup phase.

Pages end either on the last-byte flag or after 4096 accepted bytes, whichever comes first. Ending a page flushes any pending match. The final output word of the page is marked with an end flag. The stream uses a 256-symbol alphabet in which byte 0xFF acts as an escape. The second word after an escape tells a back-reference apart from a literal 0xFF.

Top module: `page_lz_small_window`

## Requirements
- R1: After reset, out_valid and out_last are 0 and in_ready is 1.
- R2: An input byte other than 0xFF that is not part of a match appears on out_data as one word equal to the byte.
- R3: A literal 0xFF is sent as the two words 0xFF, 0x00.
- R4: A back-reference is the three words 0xFF, {1, length-3 in bits 6:2, (distance-1)[9:8] in bits 1:0}, (distance-1)[7:0]. Bit 7 of the second word is always 1.
- R5: Parsing is greedy. At each position the longest match (up to the page end) is taken. Among equal lengths the smallest distance wins. A run of only one or two matching bytes is sent as that many literals, and parsing resumes at the byte that broke the run.
- R6: The match length is at most 34. A run that reaches 34 is emitted at once, and matching starts again at the next byte.
- R7: A match distance is between 1 and 1024. No byte further back than 1024 positions is ever referenced.
- R8: Pages are independent. No match reaches before the first byte of its page, and the same page sent twice compresses to the same stream.
- R9: A page ends on the handshake of a byte with in_last set, or on its 4096th accepted byte. out_last is 1 on exactly the final output word of the page, and only while out_valid is 1.
- R10: At most one output word is produced per cycle. The words of one token appear on consecutive cycles, and no input is accepted while a token is still being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is offered |
| in_ready | output | 1 | Block takes the offered byte at this edge |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Offered byte is the final byte of the page |
| out_valid | output | 1 | out_data carries a word |
| out_data | output | 8 | Compressed output word |
| out_last | output | 1 | This word is the final word of the page |

## Verification
All outputs are registered. A literal therefore shows up one cycle after the edge that accepts its byte. The first word of a back-reference shows up one cycle after the edge on which the run breaks, hits 34 or meets the page end, and its other two words follow on the next two cycles. Pending one- or two-byte runs drain as literals, one token at a time, starting on the cycle after the break. Because the exact cycle of a break depends on the data, the bench collects every output word at the falling edge together with its cycle number. It then compares the ordered stream and the end flag with a greedy reference parse, and checks from the cycle stamps that the words of each token are adjacent.

// File: rtl/page_lz_small_window.sv
module page_lz_small_window #(
  parameter int HIST = 1024,
  parameter int MAXL = 34,
  parameter int PAGE = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last
);
  localparam int HW = $clog2(HIST);
  localparam int FW = $clog2(HIST + 1);
  localparam int LW = $clog2(MAXL + 1);
  localparam int PW = $clog2(PAGE);
  localparam logic [7:0] ESC = 8'hFF;

  logic [7:0]      hist [HIST];
  logic [HIST-1:0] cand, n_cand, hit;
  logic [FW-1:0]   fill, n_fill;
  logic [LW-1:0]   len, n_len, nlen, mlen;
  logic [PW-1:0]   pcnt, n_pcnt;
  logic [7:0]      ob1, ob2, n_ob1, n_ob2, lit, lit_byte, e_d;
  logic [1:0]      ocnt, n_ocnt, lflush, n_lflush;
  logic [9:0]      moff;
  logic            eop, n_eop, e_v, e_l, acc, end_pg, take_match, take_lit, idle;

  function automatic logic [HW-1:0] lowest(input logic [HIST-1:0] v);
    lowest = '0;
    for (int i = HIST - 1; i >= 0; i--)
      if (v[i]) lowest = HW'(i);
  endfunction

  for (genvar i = 0; i < HIST; i++) begin : g_cmp
    assign hit[i] = (hist[i] == in_data) && (FW'(i) < fill) && (len == '0 || cand[i]);
  end

  assign idle     = (ocnt == 2'd0) && (lflush == 2'd0);
  assign in_ready = idle && (len == '0 || hit != '0);
  assign nlen     = len + 1'b1;
  assign end_pg   = in_last || (pcnt == PW'(PAGE - 1));
  assign lit      = hist[{{(HW-2){1'b0}}, lflush - 2'd1}];

  always_comb begin
    n_len = len; n_cand = cand; n_fill = fill; n_pcnt = pcnt;
    n_ob1 = ob1; n_ob2 = ob2; n_ocnt = ocnt; n_lflush = lflush; n_eop = eop;
    e_v = 1'b0; e_d = '0; acc = 1'b0;
    take_match = 1'b0; take_lit = 1'b0; lit_byte = in_data;
    mlen = len; moff = 10'(lowest(cand));
    if (ocnt != 2'd0) begin
      e_v = 1'b1; e_d = ob1; n_ob1 = ob2; n_ocnt = ocnt - 2'd1;
    end else if (lflush != 2'd0) begin
      take_lit = 1'b1; lit_byte = lit; n_lflush = lflush - 2'd1;
    end else if (in_valid) begin
      if (hit != '0) begin
        acc = 1'b1;
        if (nlen == LW'(MAXL) || (end_pg && nlen >= LW'(3))) begin
          take_match = 1'b1; mlen = nlen; moff = 10'(lowest(hit)); n_len = '0;
        end else if (end_pg) begin
          n_lflush = 2'(nlen); n_len = '0;
        end else begin
          n_len = nlen; n_cand = hit;
        end
      end else if (len == '0) begin
        acc = 1'b1; take_lit = 1'b1;
      end else if (len >= LW'(3)) begin
        take_match = 1'b1; n_len = '0;
      end else begin
        n_lflush = 2'(len); n_len = '0;
      end
    end
    if (take_match) begin
      e_v = 1'b1; e_d = ESC;
      n_ob1 = {1'b1, 5'(mlen - LW'(3)), moff[9:8]};
      n_ob2 = moff[7:0];
      n_ocnt = 2'd2;
    end
    if (take_lit) begin
      e_v = 1'b1; e_d = lit_byte;
      if (lit_byte == ESC) begin n_ob1 = 8'h00; n_ocnt = 2'd1; end
    end
    if (acc) begin
      n_fill = end_pg ? '0 : (fill == FW'(HIST) ? fill : fill + 1'b1);
      n_pcnt = end_pg ? '0 : pcnt + 1'b1;
      if (end_pg) n_eop = 1'b1;
    end
    e_l = e_v && n_eop && n_ocnt == 2'd0 && n_lflush == 2'd0;
    if (e_l) n_eop = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      hist[0] <= in_data;
      for (int i = 1; i < HIST; i++) hist[i] <= hist[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len <= '0; cand <= '0; fill <= '0; pcnt <= '0;
      ob1 <= '0; ob2 <= '0; ocnt <= '0; lflush <= '0; eop <= 1'b0;
      out_valid <= 1'b0; out_data <= '0; out_last <= 1'b0;
    end else begin
      len <= n_len; cand <= n_cand; fill <= n_fill; pcnt <= n_pcnt;
      ob1 <= n_ob1; ob2 <= n_ob2; ocnt <= n_ocnt; lflush <= n_lflush; eop <= n_eop;
      out_valid <= e_v; out_data <= e_d; out_last <= e_l;
    end
  end
endmodule

// File: rtl/page_lz_small_window_chk.sv
module page_lz_small_window_chk #(
  parameter int HIST = 1024,
  parameter int MAXL = 34
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         in_valid,
  input logic                         in_ready,
  input logic                         in_last,
  input logic                         out_valid,
  input logic                         out_last,
  input logic [$clog2(MAXL+1)-1:0]    len,
  input logic [HIST-1:0]              cand,
  input logic [$clog2(HIST+1)-1:0]    fill
);
  // R9
  eop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R6
  len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len < ($clog2(MAXL+1))'(MAXL));

  // R5
  cand_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len != '0 |-> cand != '0);

  // R8
  page_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last |=> fill == '0 && len == '0);

  // R7
  window_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= ($clog2(HIST+1))'(HIST));
endmodule

bind page_lz_small_window page_lz_small_window_chk #(.HIST(HIST), .MAXL(MAXL)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
  .out_valid(out_valid), .out_last(out_last), .len(len), .cand(cand), .fill(fill)
);

// File: tb/page_lz_small_window_bench.sv
module page_lz_small_window_bench;
  localparam int HIST = 1024;
  localparam int MAXL = 34;
  localparam int PAGE = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [7:0] in_data = '0, out_data;
  logic out_valid, out_last;

  always #2 clk = ~clk;

  page_lz_small_window u_page_lz_small_window (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .out_valid(out_valid), .out_data(out_data), .out_last(out_last));

  int checks = 0, errors = 0;
  longint cyc = 0;
  logic [7:0] got[$];
  logic gl[$];
  longint gc[$];
  bit seen_eop = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog (all): actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) if (rst_n && out_valid) begin
    got.push_back(out_data); gl.push_back(out_last); gc.push_back(cyc);
    if (out_last) seen_eop = 1;
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [7:0] d[$], output logic [7:0] e[$]);
    int n, p;
    n = d.size(); p = 0;
    e.delete();
    while (p < n) begin
      int best, boff, lim, dmax;
      best = 0; boff = 0;
      lim = (n - p < MAXL) ? n - p : MAXL;
      dmax = (p < HIST) ? p : HIST;
      for (int dd = 1; dd <= dmax; dd++) begin
        int l;
        l = 0;
        while (l < lim && d[p+l-dd] == d[p+l]) l++;
        if (l > best) begin best = l; boff = dd; end
      end
      if (best >= 3) begin
        logic [9:0] o;
        o = 10'(boff - 1);
        e.push_back(8'hFF); e.push_back({1'b1, 5'(best - 3), o[9:8]}); e.push_back(o[7:0]);
        p += best;
      end else begin
        int k;
        k = (best == 0) ? 1 : best;
        for (int j = 0; j < k; j++) begin
          e.push_back(d[p+j]);
          if (d[p+j] == 8'hFF) e.push_back(8'h00);
        end
        p += k;
      end
    end
  endfunction

  task automatic send_page(input logic [7:0] d[$], input bit use_last);
    for (int i = 0; i < d.size(); i++) begin
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1; in_data = d[i]; in_last = use_last && (i == d.size() - 1);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic run_page(input logic [7:0] d[$], input bit use_last, input string req);
    logic [7:0] e[$];
    int t, bad, nl, i;
    got.delete(); gl.delete(); gc.delete(); seen_eop = 0;
    model(d, e);
    send_page(d, use_last);
    t = 0;
    while (!seen_eop && t < 20000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(got.size() == e.size(), req, "stream length", got.size(), e.size());
    bad = -1;
    for (int k = 0; k < e.size() && k < got.size(); k++)
      if (bad < 0 && got[k] != e[k]) bad = k;
    chk(bad < 0, req, "word value", bad < 0 ? 0 : got[bad], bad < 0 ? 0 : e[bad]);
    nl = 0;
    foreach (gl[k]) if (gl[k]) nl++;
    chk(nl == 1 && gl.size() > 0 && gl[gl.size()-1], "R9", "end flag count", nl, 1);
    bad = 0; i = 0;
    while (i < e.size() && i < gc.size()) begin
      int w;
      w = (e[i] != 8'hFF) ? 1 : (i + 1 < e.size() && e[i+1] == 8'h00) ? 2 : 3;
      if (i + w - 1 < gc.size() && gc[i+w-1] - gc[i] != w - 1) bad++;
      i += w;
    end
    chk(bad == 0, "R10", "split tokens", bad, 0);
  endtask

  initial begin
    logic [7:0] d[$];
    logic [7:0] first[$];
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(out_valid == 1'b0 && out_last == 1'b0, "R1", "outputs after reset", {out_valid, out_last}, 0);
    chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);

    // R2: distinct bytes pass through unchanged
    d.delete();
    for (int k = 0; k < 200; k++) d.push_back(8'(k));
    run_page(d, 1, "R2");
    chk(got.size() == 200 && got[199] == 8'd199, "R2", "last literal", got.size() > 0 ? got[got.size()-1] : 0, 199);

    // R3: escape literals
    d.delete();
    for (int k = 0; k < 40; k++) d.push_back((k % 2 == 0) ? 8'hFF : 8'($urandom_range(0, 254)));
    run_page(d, 1, "R3");
    chk(got.size() >= 2 && got[0] == 8'hFF && got[1] == 8'h00, "R3", "escaped literal", got.size() >= 2 ? got[1] : 99, 0);

    // R6: long runs cap at 34
    d.delete();
    for (int k = 0; k < 100; k++) d.push_back(8'h00);
    run_page(d, 1, "R6");
    chk(got.size() >= 4 && got[1] == 8'hFF && got[2] == 8'hFC && got[3] == 8'h00, "R6", "first run token", got.size() >= 3 ? got[2] : 0, 8'hFC);
    chk(got.size() >= 3 && got[got.size()-2] == 8'hF0, "R6", "tail run token", got.size() >= 2 ? got[got.size()-2] : 0, 8'hF0);

    // R4/R7: distance 1024 accepted
    d.delete();
    for (int k = 0; k < 8; k++) d.push_back(8'(k));
    for (int k = 0; k < 1016; k++) d.push_back(8'($urandom_range(128, 254)));
    for (int k = 0; k < 8; k++) d.push_back(8'(k));
    run_page(d, 1, "R7");
    chk(got.size() >= 3 && got[got.size()-3] == 8'hFF && got[got.size()-2] == 8'h97 && got[got.size()-1] == 8'hFF,
        "R4", "distance 1024 token", got.size() >= 2 ? got[got.size()-2] : 0, 8'h97);

    // R7: distance 1025 out of reach
    d.delete();
    for (int k = 0; k < 8; k++) d.push_back(8'(k));
    for (int k = 0; k < 1017; k++) d.push_back(8'($urandom_range(128, 254)));
    for (int k = 0; k < 8; k++) d.push_back(8'(k));
    run_page(d, 1, "R7");
    chk(got.size() >= 8 && got[got.size()-1] == 8'd7 && got[got.size()-8] == 8'd0, "R7", "tail as literals",
        got.size() > 0 ? got[got.size()-1] : 0, 7);

    // R5 and R8: small alphabet, page repeated
    d.delete();
    for (int k = 0; k < 300; k++) d.push_back(8'($urandom_range(0, 3)));
    run_page(d, 1, "R5");
    first = got;
    run_page(d, 1, "R8");
    chk(got == first, "R8", "repeat page same stream", got.size(), first.size());

    // R9: page closes at 4096 bytes without the flag
    d.delete();
    for (int k = 0; k < PAGE; k++) d.push_back(8'($urandom_range(0, 15)));
    run_page(d, 0, "R9");
    d.delete();
    for (int k = 0; k < 20; k++) d.push_back(8'($urandom_range(0, 15)));
    run_page(d, 1, "R8");

    // R5: mixed random pages, including very short ones
    for (int r = 0; r < 6; r++) begin
      int n;
      n = (r == 0) ? 1 : (r == 1) ? 2 : $urandom_range(3, 400);
      d.delete();
      for (int k = 0; k < n; k++)
        d.push_back(($urandom_range(0, 9) == 0) ? 8'hFF : 8'($urandom_range(0, 1 + r * 2)));
      run_page(d, 1, "R5");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule